// File: doc/BRIEF.md
# Periodic Button Change Reporter

This block watches a small group of button pins and tells the host when their combined state changes. A free-running divider produces a poll tick every `POLL_CYCLES` clock cycles (about 17 ms at the default setting and a 125 MHz clock). On each tick the block samples the synchronized pins. It compares the sample with the last state the host actually accepted. When the two differ, it raises a two-byte report for an interrupt IN endpoint. The report is a pin bitmap: the low byte carries buttons 0..7 and the high byte carries buttons 8..15.

Reporting runs only while two gates are both high: a configuration bit that turns the button function on, and a flag that says a HID descriptor is stored. At most one report is outstanding at a time. A report waits until the endpoint signals that it is ready. While it waits, later polls refresh its contents with the newest sample. The reference state moves only when the endpoint accepts a report, so a change is never lost. The first poll after reset always produces a report, so the host learns the initial state.

Top module: `btn_change_reporter`

## Requirements
- R1: A poll tick occurs once every `POLL_CYCLES` clock cycles, and the divider restarts at reset. With both gates high and buttons stable, the first `rpt_valid_o` rises exactly `POLL_CYCLES` rising edges after reset release. Later reports for changes presented right after the previous report are spaced exactly `POLL_CYCLES` cycles apart.
- R2: The first enabled poll after reset raises a report even when every button is 0.
- R3: Apart from R2, a poll raises a report only if the sampled state differs from the last accepted report. A stable state produces no further reports.
- R4: `rpt_byte0_o` bit i equals button i for i = 0..7, and `rpt_byte1_o` bit j equals button 8+j. Bit positions at or above `NUM_BTN` read 0. Both bytes read 0 whenever `rpt_valid_o` is low.
- R5: If `hid_en_i` or `hid_desc_i` is low in a cycle, `rpt_valid_o` is low in the next cycle and any pending report is dropped. No report is raised while either gate is low.
- R6: A raised report stays valid with unchanged bytes until a cycle in which `ep_ready_i` is high. It is then accepted and `rpt_valid_o` falls in the next cycle, unless a poll in that same cycle finds a new change.
- R7: A poll that happens while a report is pending replaces the report contents with the new sample. The report stays pending.
- R8: The last-reported state is updated only when a report is accepted. A change whose report was dropped or never accepted is reported again on a later enabled poll.
- R9: Each button passes through a two-flop synchronizer. A level held for at least two cycles before a poll is the value that poll captures, including levels held during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_i | input | NUM_BTN | Raw button levels |
| hid_en_i | input | 1 | Button function enabled by configuration |
| hid_desc_i | input | 1 | HID descriptor present in stored configuration |
| ep_ready_i | input | 1 | Endpoint accepts the offered report this cycle |
| rpt_valid_o | output | 1 | A report is offered |
| rpt_byte0_o | output | 8 | Report byte 0: buttons 0..7 |
| rpt_byte1_o | output | 8 | Report byte 1: buttons 8..15 |

## Verification
The assertions check these behaviours on every cycle:
- the divider stays in range;
- a new report appears only right after an enabled poll tick;
- a pending report holds still until it is accepted or refreshed;
- an accept clears the report;
- a low gate clears it in the next cycle;
- the reference state moves only on accept;
- unused and idle byte bits stay 0.

The bench scenarios cover what the assertions cannot see. They time the exact first-report latency and the spacing between reports. They sweep every value of a 12-button configuration through the bitmap. They also show that a dropped or unaccepted change comes back once the gates reopen, and that an overwritten pending report carries the latest state.

// File: rtl/btn_rpt_pkg.sv
package btn_rpt_pkg;

  localparam int MAX_BTN = 16;

  typedef struct packed {
    logic [7:0] hi;
    logic [7:0] lo;
  } rpt_bytes_t;

  // Mask with one bit set for every wired button position.
  function automatic logic [MAX_BTN-1:0] btn_mask(input int n);
    logic [MAX_BTN-1:0] m;
    m = '0;
    for (int i = 0; i < MAX_BTN; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Split a button state into the two report bytes, unused bits cleared.
  function automatic rpt_bytes_t pack_report(input logic [MAX_BTN-1:0] st, input int n);
    logic [MAX_BTN-1:0] v;
    rpt_bytes_t r;
    v = st & btn_mask(n);
    r.lo = v[7:0];
    r.hi = v[15:8];
    return r;
  endfunction

  // A poll is a change if nothing was reported yet or the state moved.
  function automatic logic is_change(input logic never_sent,
                                     input logic [MAX_BTN-1:0] now_st,
                                     input logic [MAX_BTN-1:0] ref_st);
    return never_sent || (now_st != ref_st);
  endfunction

endpackage

// File: rtl/btn_sync2.sv
module btn_sync2 #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic meta_q;
    logic stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= async_i[g];
        stab_q <= meta_q;
      end
    end
    assign sync_o[g] = stab_q;
  end

endmodule

// File: rtl/poll_divider.sv
module poll_divider #(
  parameter int POLL_CYCLES = 2_125_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic poll_tick_o
);

  localparam int CW = $clog2(POLL_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(POLL_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (wrap) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  assign poll_tick_o = wrap;

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R1
  tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_tick_o |=> (cnt_q == '0));

endmodule

// File: rtl/report_slot.sv
module report_slot
  import btn_rpt_pkg::*;
#(
  parameter int NUM_BTN = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable_i,
  input  logic               poll_tick_i,
  input  logic [MAX_BTN-1:0] sample_i,
  input  logic               ep_ready_i,
  output logic               valid_o,
  output logic [MAX_BTN-1:0] payload_o
);

  logic               valid_q, valid_d;
  logic [MAX_BTN-1:0] payload_q, payload_d;
  logic [MAX_BTN-1:0] last_q;
  logic               fresh_q;

  // Named internal events for the checks below.
  logic               accept_ev;
  logic               poll_ev;
  logic               change_ev;
  logic [MAX_BTN-1:0] ref_state;
  logic               ref_fresh;

  assign accept_ev = valid_q && ep_ready_i;
  assign poll_ev   = enable_i && poll_tick_i;
  assign ref_state = accept_ev ? payload_q : last_q;
  assign ref_fresh = accept_ev ? 1'b0 : fresh_q;
  assign change_ev = is_change(ref_fresh, sample_i & btn_mask(NUM_BTN), ref_state);

  always_comb begin
    valid_d   = valid_q;
    payload_d = payload_q;
    if (!enable_i) begin
      valid_d = 1'b0;
    end else begin
      if (accept_ev) valid_d = 1'b0;
      if (poll_ev) begin
        if (valid_q && !accept_ev) begin
          payload_d = sample_i & btn_mask(NUM_BTN);
        end else if (change_ev) begin
          valid_d   = 1'b1;
          payload_d = sample_i & btn_mask(NUM_BTN);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      payload_q <= '0;
      last_q    <= '0;
      fresh_q   <= 1'b1;
    end else begin
      valid_q   <= valid_d;
      payload_q <= payload_d;
      if (accept_ev) begin
        last_q  <= payload_q;
        fresh_q <= 1'b0;
      end
    end
  end

  assign valid_o   = valid_q;
  assign payload_o = payload_q;

  // R3
  rise_on_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> $past(poll_ev));

  // R5
  gate_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> !valid_q);

  // R6
  hold_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ep_ready_i && enable_i && !poll_tick_i) |=> (valid_q && $stable(payload_q)));

  // R6
  accept_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_ev && !poll_ev) |=> !valid_q);

  // R8
  ref_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_ev |=> $stable(last_q));

endmodule

// File: rtl/btn_change_reporter.sv
module btn_change_reporter
  import btn_rpt_pkg::*;
#(
  parameter int NUM_BTN     = 16,
  parameter int POLL_CYCLES = 2_125_000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_BTN-1:0] btn_i,
  input  logic               hid_en_i,
  input  logic               hid_desc_i,
  input  logic               ep_ready_i,
  output logic               rpt_valid_o,
  output logic [7:0]         rpt_byte0_o,
  output logic [7:0]         rpt_byte1_o
);

  localparam logic [MAX_BTN-1:0] WIRED = btn_mask(NUM_BTN);

  logic [NUM_BTN-1:0] btn_s;
  logic [MAX_BTN-1:0] btn_wide;
  logic               poll_tick;
  logic               gate_open;
  logic               slot_valid;
  logic [MAX_BTN-1:0] slot_payload;
  rpt_bytes_t         rpt;
  logic [MAX_BTN-1:0] rpt_word;

  btn_sync2 #(.WIDTH(NUM_BTN)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (btn_i),
    .sync_o  (btn_s)
  );

  poll_divider #(.POLL_CYCLES(POLL_CYCLES)) div_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .poll_tick_o (poll_tick)
  );

  always_comb begin
    btn_wide = '0;
    btn_wide[NUM_BTN-1:0] = btn_s;
  end

  assign gate_open = hid_en_i && hid_desc_i;

  report_slot #(.NUM_BTN(NUM_BTN)) slot_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable_i    (gate_open),
    .poll_tick_i (poll_tick),
    .sample_i    (btn_wide),
    .ep_ready_i  (ep_ready_i),
    .valid_o     (slot_valid),
    .payload_o   (slot_payload)
  );

  always_comb begin
    rpt = pack_report(slot_payload, NUM_BTN);
    if (!slot_valid) rpt = '0;
  end

  assign rpt_valid_o = slot_valid;
  assign rpt_byte0_o = rpt.lo;
  assign rpt_byte1_o = rpt.hi;
  assign rpt_word    = {rpt_byte1_o, rpt_byte0_o};

  // R4
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_word & ~WIRED) == '0);

  // R4
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rpt_valid_o |-> (rpt_word == '0));

endmodule

// File: tb/btn_change_reporter_tb_top.sv
module btn_change_reporter_tb_top;

  localparam int NB = 12;
  localparam int P  = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NB-1:0] btn = '0;
  logic          hid_en = 1'b1;
  logic          hid_desc = 1'b1;
  logic          ep_ready = 1'b1;
  logic          rpt_valid;
  logic [7:0]    b0, b1;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  btn_change_reporter #(.NUM_BTN(NB), .POLL_CYCLES(P)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .btn_i       (btn),
    .hid_en_i    (hid_en),
    .hid_desc_i  (hid_desc),
    .ep_ready_i  (ep_ready),
    .rpt_valid_o (rpt_valid),
    .rpt_byte0_o (b0),
    .rpt_byte1_o (b1)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_bytes(input string req, input int v);
    int e0, e1;
    e0 = v % 256;
    e1 = (v / 256) % (1 << (NB - 8));
    chk(b0 == e0[7:0], req, b0, e0);
    chk(b1 == e1[7:0], req, b1, e1);
  endtask

  task automatic wait_report(input int limit, output bit seen, output int waited);
    seen = 1'b0;
    waited = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      waited++;
      if (rpt_valid) begin
        seen = 1'b1;
        break;
      end
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit seen;
    int waited;
    int prev;

    btn = NB'(12'h5A3);
    repeat (4) @(negedge clk);
    chk(rpt_valid == 1'b0, "R4 reset valid", rpt_valid, 0);
    chk({b1, b0} == 16'h0, "R4 reset bytes", {b1, b0}, 0);
    rst_n = 1'b1;

    // R1 first report latency, R2 initial report, R9 level held in reset
    wait_report(3 * P, seen, waited);
    chk(seen, "R2 first report", seen, 1);
    chk(waited == P, "R1 first latency", waited, P);
    chk_bytes("R9 initial sample", 12'h5A3);
    prev = 12'h5A3;

    // R4 exhaustive bitmap sweep, R1 spacing, R3 change detection
    for (int v = 0; v < (1 << NB); v++) begin
      if (v == prev) continue;
      btn = NB'(v);
      wait_report(3 * P, seen, waited);
      chk(seen, "R3 change reported", seen, 1);
      chk(waited == P, "R1 report spacing", waited, P);
      chk_bytes("R4 bitmap", v);
      prev = v;
    end

    // R3 stable input: no reports
    wait_report(3 * P, seen, waited);
    chk(!seen, "R3 no report when stable", seen, 0);

    // R6, R7 pending hold and overwrite
    ep_ready = 1'b0;
    btn = NB'(12'h0F0);
    wait_report(3 * P, seen, waited);
    chk(seen, "R6 pending raised", seen, 1);
    chk_bytes("R6 pending bytes", 12'h0F0);
    btn = NB'(12'h00F);
    repeat (P + 2) @(negedge clk);
    chk(rpt_valid == 1'b1, "R6 held while not ready", rpt_valid, 1);
    chk_bytes("R7 overwrite", 12'h00F);
    ep_ready = 1'b1;
    @(negedge clk);
    chk(rpt_valid == 1'b0, "R6 clear after accept", rpt_valid, 0);
    wait_report(3 * P, seen, waited);
    chk(!seen, "R8 accepted state is reference", seen, 0);

    // R5, R8 drop on gate low, recover later
    ep_ready = 1'b0;
    btn = NB'(12'hC3C);
    wait_report(3 * P, seen, waited);
    chk(seen, "R5 report before gating", seen, 1);
    hid_en = 1'b0;
    @(negedge clk);
    chk(rpt_valid == 1'b0, "R5 enable low drops", rpt_valid, 0);
    chk({b1, b0} == 16'h0, "R4 idle bytes", {b1, b0}, 0);
    wait_report(3 * P, seen, waited);
    chk(!seen, "R5 no report while disabled", seen, 0);
    hid_en = 1'b1;
    wait_report(3 * P, seen, waited);
    chk(seen, "R8 dropped change returns", seen, 1);
    chk_bytes("R8 returned bytes", 12'hC3C);
    ep_ready = 1'b1;
    @(negedge clk);

    hid_desc = 1'b0;
    btn = NB'(12'h812);
    wait_report(3 * P, seen, waited);
    chk(!seen, "R5 no report without descriptor", seen, 0);
    hid_desc = 1'b1;
    wait_report(3 * P, seen, waited);
    chk(seen, "R8 change reported after descriptor", seen, 1);
    chk_bytes("R8 descriptor bytes", 12'h812);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule